// File: doc/BRIEF.md
# Byte-Bus Loadable Synchronous Counter Bank

This block is a wide synchronous counter split into equal byte slices. It sits on a single shared byte bus driven by a host controller. The host picks a slice with that slice's active-low select. It then either writes the bus byte into the slice with the active-low load strobe, or reads the slice's count back with the active-low read strobe. A full preset of the default 24-bit bank takes three load cycles, one per slice, in any order. Slice 0 holds bits 7:0 and the highest slice holds the most significant byte.

All slices share one clock, and each slice's next value depends only on register state from the previous edge, so every bit changes on the same edge. Counting runs while the active-low count enable is low. A direction input selects up or down counting. Each slice drives an active-low terminal flag. The flag of the top slice rises early, one low-slice period (256 counts) before the whole bank wraps, which a host can use to end a timing window. At the block's edge, tri-state is modelled as a drive-enable output plus a read-data output.

Top module: `bytebus_counter`

## Requirements
- R1: After the asynchronous reset is released, every slice holds zero, `bus_drive` is 0, and with `cnt_en_n` high every bit of `tc_n` is 1.
- R2: When `sel_n[k]` and `load_n` are both low, slice k holds `bus_in` after the next rising edge. Slices whose select is high keep their value, apart from counting.
- R3: When `sel_n[k]`, `oen_n` are low and `load_n` is high, `bus_drive` is 1 and `bus_out` shows slice k's current count in the same cycle. With no such slice, `bus_drive` is 0. If several slices are selected, the lowest index is read.
- R4: With `cnt_en_n` high, no slice changes except through a load.
- R5: With `cnt_en_n` low, the bank steps by one on each edge: up when `up_dn` is 1, down when it is 0. A carry or borrow into an upper slice takes effect on the same edge as the low slice's step.
- R6: Counting up wraps from 0xFFFFFF to 0x000000, and counting down wraps from 0x000000 to 0xFFFFFF.
- R7: The terminal value of a slice is 0xFF when counting up and 0x00 when counting down. `tc_n[0]` is low when `cnt_en_n` is low and slice 0 is terminal. For k of 1 or more, `tc_n[k]` is low when `cnt_en_n` is low and slices 1 through k are all terminal. So the top flag asserts 256 counts before the full wrap.
- R8: A load on a slice takes priority over a count step of that slice on the same edge. The other slices still count, using the pre-edge values.
- R9: If `load_n` and `oen_n` are both low on a selected slice, the load takes place and the block does not drive the bus (`bus_drive` is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | N_SLICES | Per-slice active-low select |
| load_n | input | 1 | Active-low parallel load strobe |
| oen_n | input | 1 | Active-low read strobe |
| cnt_en_n | input | 1 | Active-low count enable |
| up_dn | input | 1 | 1 counts up, 0 counts down |
| bus_in | input | SLICE_W | Byte from host for loading |
| bus_out | output | SLICE_W | Byte read from the selected slice |
| bus_drive | output | 1 | High when the block drives the bus |
| tc_n | output | N_SLICES | Active-low terminal flags, one per slice |

## Verification
The only way to see the count is a byte read, so a corrupted slice register appears on `bus_out` at the next read of that slice. A broken carry between slices shows up only when the low slice wraps. For that reason the bench reads all three slices as counts cross slice boundaries and wrap the whole bank. A wrong terminal decode, or a wrong enable chain, shows up on `tc_n` in the very cycle the terminal value is reached, because the flags are combinational from state. Each cycle's flags and read data are compared against an independent model in that cycle.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/bbc_rst_sync.sv
module bbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage1  <= 1'b1;
      rst_q_n <= stage1;
    end
  end
endmodule

// File: rtl/bbc_slice.sv
module bbc_slice
  import bbc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         load_n,
  input  logic         up,
  input  logic         carry_in,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         at_term
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         load_hit;
  logic         q_en;
  logic [W-1:0] q_nxt;
  dir_e         dir;

  assign dir      = dir_e'(up);
  assign load_hit = !sel_n && !load_n;
  assign q_en     = load_hit || carry_in;
  assign at_term  = (dir == DIR_UP) ? (&q) : ~(|q);

  always_comb begin
    q_nxt = q;
    if (load_hit)            q_nxt = d;
    else if (dir == DIR_UP)  q_nxt = q + ONE;
    else                     q_nxt = q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R2 / R8: a load wins over a step
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |=> (q == $past(d)));
  // R4: no enable, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hit && !carry_in) |=> $stable(q));
  // R5: step size and direction
  p_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hit && carry_in && up) |=> (q == $past(q) + ONE));
  p_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hit && carry_in && !up) |=> (q == $past(q) - ONE));
endmodule

// File: rtl/bbc_chain.sv
module bbc_chain #(
  parameter int N = 3
) (
  input  logic         en,
  input  logic [N-1:0] term,
  output logic [N-1:0] carry,
  output logic [N-1:0] tc_n
);
  logic [N-1:0] hi_run;

  assign carry[0]  = en;
  assign hi_run[0] = en && term[0];

  generate
    for (genvar k = 1; k < N; k++) begin : g_link
      assign carry[k] = carry[k-1] && term[k-1];
      if (k == 1) begin : g_first
        assign hi_run[k] = en && term[k];
      end else begin : g_rest
        assign hi_run[k] = hi_run[k-1] && term[k];
      end
    end
  endgenerate

  assign tc_n = ~hi_run;
endmodule

// File: rtl/bbc_rdmux.sv
module bbc_rdmux #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic [N-1:0]   sel_n,
  input  logic           load_n,
  input  logic           oen_n,
  input  logic [N*W-1:0] cnt_flat,
  output logic [W-1:0]   rd,
  output logic           drive
);
  always_comb begin
    rd    = '0;
    drive = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (!sel_n[k] && !oen_n && load_n) begin
        rd    = cnt_flat[k*W +: W];
        drive = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bytebus_counter.sv
module bytebus_counter #(
  parameter int SLICE_W  = 8,
  parameter int N_SLICES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SLICES-1:0] sel_n,
  input  logic                load_n,
  input  logic                oen_n,
  input  logic                cnt_en_n,
  input  logic                up_dn,
  input  logic [SLICE_W-1:0]  bus_in,
  output logic [SLICE_W-1:0]  bus_out,
  output logic                bus_drive,
  output logic [N_SLICES-1:0] tc_n
);
  localparam int TOTAL_W = SLICE_W * N_SLICES;

  logic               rst_q_n;
  logic [N_SLICES-1:0] term;
  logic [N_SLICES-1:0] carry;
  logic [TOTAL_W-1:0]  cnt_flat;

  bbc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bbc_chain #(.N(N_SLICES)) u_chain (
    .en    (!cnt_en_n),
    .term  (term),
    .carry (carry),
    .tc_n  (tc_n)
  );

  generate
    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
      bbc_slice #(.W(SLICE_W)) u_slice (
        .clk      (clk),
        .rst_n    (rst_q_n),
        .sel_n    (sel_n[k]),
        .load_n   (load_n),
        .up       (up_dn),
        .carry_in (carry[k]),
        .d        (bus_in),
        .q        (cnt_flat[k*SLICE_W +: SLICE_W]),
        .at_term  (term[k])
      );
    end
  endgenerate

  bbc_rdmux #(.N(N_SLICES), .W(SLICE_W)) u_rd (
    .sel_n    (sel_n),
    .load_n   (load_n),
    .oen_n    (oen_n),
    .cnt_flat (cnt_flat),
    .rd       (bus_out),
    .drive    (bus_drive)
  );

  // R1: bank is clear on the first edge after reset release
  p_clear_r1: assert property (@(posedge clk)
    $rose(rst_q_n) |-> (cnt_flat == '0));
  // R9: no drive while a load strobe is active
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !load_n |-> !bus_drive);

  // R7: upper flags nest
  generate
    for (genvar k = 2; k < N_SLICES; k++) begin : g_tcchk
      p_tc_nest_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
        !tc_n[k] |-> !tc_n[k-1]);
    end
  endgenerate
endmodule

// File: tb/bytebus_counter_tb_top.sv
`timescale 1ns/1ps
module bytebus_counter_tb_top;
  localparam int W   = 8;
  localparam int N   = 3;
  localparam int TOT = W * N;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] sel_n;
  logic         load_n, oen_n, cnt_en_n, up_dn;
  logic [W-1:0] bus_in;
  logic [W-1:0] bus_out;
  logic         bus_drive;
  logic [N-1:0] tc_n;

  always #2.5 clk = ~clk;

  bytebus_counter #(.SLICE_W(W), .N_SLICES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .load_n(load_n),
    .oen_n(oen_n), .cnt_en_n(cnt_en_n), .up_dn(up_dn), .bus_in(bus_in),
    .bus_out(bus_out), .bus_drive(bus_drive), .tc_n(tc_n)
  );

  typedef struct packed {
    logic         drv;
    logic [W-1:0] rd;
    logic [N-1:0] tc;
  } exp_t;

  exp_t         q_exp[$];
  string        q_req[$];
  logic [TOT-1:0] model;
  int           checks = 0;
  int           errors = 0;
  logic         mon_on = 1'b0;
  logic         done   = 1'b0;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic is_term(input logic [W-1:0] v, input logic up);
    return up ? (v == {W{1'b1}}) : (v == {W{1'b0}});
  endfunction

  // driver: one bus cycle, expected results into the scoreboard queue
  task automatic step(input logic [N-1:0] s, input logic ld, input logic oe,
                      input logic en_n, input logic up, input logic [W-1:0] d,
                      input string req);
    exp_t e;
    logic en;
    logic run;
    logic [TOT-1:0] nxt;
    @(negedge clk);
    sel_n = s; load_n = ld; oen_n = oe; cnt_en_n = en_n; up_dn = up; bus_in = d;
    if (!ld && !oe && (s != '1))
      $display("NOTE: illegal load with read strobe on select %b", s);
    en = !en_n;
    e.drv = 1'b0;
    e.rd  = '0;
    for (int k = N - 1; k >= 0; k--)
      if (!s[k] && !oe && ld) begin
        e.drv = 1'b1;
        e.rd  = model[k*W +: W];
      end
    e.tc[0] = !(en && is_term(model[W-1:0], up));
    run = en;
    for (int k = 1; k < N; k++) begin
      run = run && is_term(model[k*W +: W], up);
      e.tc[k] = !run;
    end
    q_exp.push_back(e);
    q_req.push_back(req);
    nxt = model;
    run = en;
    for (int k = 0; k < N; k++) begin
      if (!s[k] && !ld) nxt[k*W +: W] = d;
      else if (run) nxt[k*W +: W] = up ? model[k*W +: W] + 8'd1 : model[k*W +: W] - 8'd1;
      run = run && is_term(model[k*W +: W], up);
    end
    model = nxt;
  endtask

  task automatic load_byte(input int k, input logic [W-1:0] d, input logic en_n,
                           input logic up, input string req);
    logic [N-1:0] s;
    s = '1; s[k] = 1'b0;
    step(s, 1'b0, 1'b1, en_n, up, d, req);
  endtask

  task automatic read_byte(input int k, input logic en_n, input logic up,
                           input string req);
    logic [N-1:0] s;
    s = '1; s[k] = 1'b0;
    step(s, 1'b1, 1'b0, en_n, up, '0, req);
  endtask

  task automatic read_all(input logic en_n, input logic up, input string req);
    for (int k = 0; k < N; k++) read_byte(k, en_n, up, req);
  endtask

  // monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    if (mon_on) begin
      #1;
      if (q_exp.size() > 0) begin
        exp_t e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        check(bus_drive == e.drv, r, "drive", 32'(bus_drive), 32'(e.drv));
        if (e.drv) check(bus_out == e.rd, r, "read", 32'(bus_out), 32'(e.rd));
        check(tc_n == e.tc, {r, " R7"}, "tc_n", 32'(tc_n), 32'(e.tc));
      end
    end
  end

  initial begin
    rst_n = 1'b0; sel_n = '1; load_n = 1'b1; oen_n = 1'b1;
    cnt_en_n = 1'b1; up_dn = 1'b1; bus_in = '0; model = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(bus_drive == 1'b0, "R1", "drive after reset", 32'(bus_drive), 0);
    check(tc_n == '1, "R1", "tc after reset", 32'(tc_n), 32'h7);
    mon_on = 1'b1;
    read_all(1'b1, 1'b1, "R1");
    // R2 / R3: preset each slice then read back
    load_byte(0, 8'hA5, 1'b1, 1'b1, "R2");
    load_byte(2, 8'h7E, 1'b1, 1'b1, "R2");
    load_byte(1, 8'h3C, 1'b1, 1'b1, "R2");
    read_all(1'b1, 1'b1, "R3");
    step(3'b010, 1'b1, 1'b0, 1'b1, 1'b1, '0, "R3");
    step(3'b111, 1'b1, 1'b0, 1'b1, 1'b1, '0, "R3");
    // R4: disabled counter holds, direction flips do nothing
    for (int i = 0; i < 4; i++) step('1, 1'b1, 1'b1, 1'b1, i[0], '0, "R4");
    read_all(1'b1, 1'b0, "R4");
    // R5 / R7: count up across slice borders to the early top flag
    load_byte(0, 8'hFE, 1'b1, 1'b1, "R2");
    load_byte(1, 8'hFE, 1'b1, 1'b1, "R2");
    load_byte(2, 8'hFF, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 3; i++) step('1, 1'b1, 1'b1, 1'b0, 1'b1, '0, "R5");
    read_all(1'b0, 1'b1, "R7");
    // R6: run through the full up wrap, reading while counting
    for (int i = 0; i < 260; i++) read_byte(i % N, 1'b0, 1'b1, "R6");
    // R8: load slice 1 while a carry into it is pending
    load_byte(0, 8'hFF, 1'b1, 1'b1, "R2");
    load_byte(1, 8'h20, 1'b0, 1'b1, "R8");
    read_all(1'b1, 1'b1, "R8");
    load_byte(0, 8'h80, 1'b0, 1'b1, "R8");
    read_all(1'b1, 1'b1, "R8");
    // R6 / R7: count down from zero and wrap to all ones
    for (int k = 0; k < N; k++) load_byte(k, 8'h00, 1'b1, 1'b0, "R2");
    step('1, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R6");
    read_all(1'b1, 1'b0, "R6");
    for (int i = 0; i < 6; i++) read_byte(i % N, 1'b0, 1'b0, "R5");
    // R5: carry into middle slice on the same edge
    load_byte(0, 8'hFF, 1'b1, 1'b1, "R2");
    step('1, 1'b1, 1'b1, 1'b0, 1'b1, '0, "R5");
    read_all(1'b1, 1'b1, "R5");
    // R9: illegal load with read strobe: loads, no drive
    step(3'b101, 1'b0, 1'b0, 1'b1, 1'b1, 8'h55, "R9");
    read_byte(1, 1'b1, 1'b1, "R9");
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule